// File: doc/BRIEF.md
# Mode-Aware General-Purpose I/O Port Register Block

This block is one 8-bit general-purpose I/O port together with its three memory-mapped registers. A write-only direction register chooses, pin by pin, whether each pin drives or listens. A read/write output register holds the values the driving pins present. A read-only pin-state register returns the pin levels after one register stage. Each pin has its own output value and output enable, so it can feed a tri-state pad.

When the chip runs in one of its three external-bus modes, any of the four low pins can be handed over to the bus controller as address outputs, one enable bit per pin. In single-chip mode every pin follows the direction and output registers. A power-on reset clears both writable registers. A manual reset keeps them, and the pins go on driving what the retained registers say. Hardware standby clears the direction register, and software standby keeps it. A hold control picks whether the address pins keep their last value in software standby or float.

The bus presents an address, a write strobe and write data. Only the low 16 address bits are decoded, and the read data follows the address without a clock.

Top module: `gpio_port_regs`

## Requirements
- R1: After power-on reset (`rst_n_i` low, then released), the direction and output registers are 0x00, so every `pin_oe_o` bit is 0 and a read of the output register address returns 0x00.
- R2: A write with `wr_en_i` high to low address 0xFF00 loads the output register at that clock edge, whatever the address bits above bit 15 are. A later read of 0xFF00 returns the written byte.
- R3: A write to low address 0xFE30 loads the direction register. A read of 0xFE30 always returns 0xFF, never the stored value.
- R4: A read of low address 0xFFB0 returns `pin_i` as it was sampled at the most recent rising clock edge (one register stage).
- R5: With `mode_i` = 3 (single-chip), for every pin k, `pin_oe_o[k]` equals direction bit k and `pin_o[k]` equals output register bit k.
- R6: With `mode_i` = 0, 1 or 2 (external-bus modes) and `aen_i[k]` = 1 for some k in 0..3, pin k drives `addr_bits_i[k]` with its enable at 1. Pins 7..4, and any low pin whose `aen_i` bit is 0, behave as in R5.
- R7: While `hw_stby_i` is high at a clock edge, the direction register is cleared at that edge and all non-address pins stop driving. The output register keeps its value.
- R8: While `man_rst_i` is high, bus writes are ignored and both registers keep their contents. The pins keep being driven from those retained contents.
- R9: With `sw_stby_i` high, both registers are retained. A pin acting as an address output (R6) drives the address bit captured at the last clock edge before standby if `hold_i` = 1, and has its enable at 0 if `hold_i` = 0.
- R10: A write to any other low address changes no register, and a read of any other low address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Power-on reset, asynchronous, active low |
| man_rst_i | input | 1 | Manual reset, active high, keeps registers |
| hw_stby_i | input | 1 | Hardware standby, clears the direction register |
| sw_stby_i | input | 1 | Software standby |
| hold_i | input | 1 | In software standby: 1 keeps address pins driving, 0 floats them |
| mode_i | input | 2 | 0,1,2 = external-bus modes; 3 = single-chip mode |
| aen_i | input | 4 | Per-pin address-output enable for pins 3..0 |
| addr_bits_i | input | 4 | Address bits from the bus controller for pins 3..0 |
| bus_addr_i | input | 24 | Register address; only bits 15..0 are decoded |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Per-pin output value |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: 8 pins, 4 of them address-capable, a 24-bit bus address and a 16-bit decode. At that size it can sweep all 256 output-register values and all 256 pin patterns, plus every pairing of the four modes with the sixteen address-enable patterns over several direction and data patterns. The upper address bits vary during the sweeps to show that they are ignored. The reset, manual-reset and standby orderings are run as directed sequences, and the pin outputs and register readback are checked after each step.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_EXT_A  = 2'd0,
    MODE_EXT_B  = 2'd1,
    MODE_EXT_C  = 2'd2,
    MODE_SINGLE = 2'd3
  } op_mode_e;

  function automatic logic is_ext_mode(op_mode_e m);
    return (m != MODE_SINGLE);
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_q
);

  logic [W-1:0] pin_d;

  always_comb begin
    pin_d = pin_raw;
  end

  always_ff @(posedge clk) begin
    pin_q <= pin_d;
  end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file #(
  parameter int             W       = 8,
  parameter int             DEC_AW  = 16,
  parameter logic [DEC_AW-1:0] DIR_OFS = 16'hFE30,
  parameter logic [DEC_AW-1:0] DAT_OFS = 16'hFF00,
  parameter logic [DEC_AW-1:0] PIN_OFS = 16'hFFB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic [DEC_AW-1:0] dec_addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dat_q,
  output logic [W-1:0]      rdata
);

  localparam logic [W-1:0] DIR_READ_PAT = '1;

  logic         sel_dir;
  logic         sel_dat;
  logic         sel_pin;
  logic         wr_ok;
  logic         dir_ce;
  logic         dat_ce;
  logic [W-1:0] dir_d;
  logic [W-1:0] dat_d;

  // address decode
  always_comb begin
    sel_dir = (dec_addr == DIR_OFS);
    sel_dat = (dec_addr == DAT_OFS);
    sel_pin = (dec_addr == PIN_OFS);
    wr_ok   = wr_en && !man_rst;
  end

  // next-state logic
  always_comb begin
    dir_ce = hw_stby || (wr_ok && sel_dir);
    dir_d  = hw_stby ? '0 : wdata;
    dat_ce = wr_ok && sel_dat;
    dat_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_ce) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_ce) begin
      dat_q <= dat_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (sel_dir) rdata = DIR_READ_PAT;
    if (sel_dat) rdata = dat_q;
    if (sel_pin) rdata = pin_q;
  end

  AST_HWSTBY_CLEARS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0)); // R7

  AST_MANRST_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst && !hw_stby) |=> ($stable(dir_q) && $stable(dat_q))); // R8

  AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_addr == DIR_OFS) |-> (rdata == DIR_READ_PAT)); // R3

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && dec_addr != DIR_OFS && dec_addr != DAT_OFS)
      |=> ($stable(dir_q) && $stable(dat_q))); // R10

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int NA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_mode_e      mode,
  input  logic [NA-1:0] aen,
  input  logic [NA-1:0] addr_bits,
  input  logic          sw_stby,
  input  logic          hold,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  dat_q,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe
);

  logic          ext;
  logic [NA-1:0] addr_q;
  logic [NA-1:0] addr_d;
  logic          addr_ce;

  always_comb begin
    ext     = is_ext_mode(mode);
    addr_ce = !sw_stby;
    addr_d  = addr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_ce) begin
      addr_q <= addr_d;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    if (k < NA) begin : g_addr_capable
      logic addr_act;

      always_comb begin
        addr_act = ext && aen[k];
        if (addr_act) begin
          if (sw_stby) begin
            pin_o[k]  = addr_q[k];
            pin_oe[k] = hold;
          end else begin
            pin_o[k]  = addr_bits[k];
            pin_oe[k] = 1'b1;
          end
        end else begin
          pin_o[k]  = dat_q[k];
          pin_oe[k] = dir_q[k];
        end
      end

      AST_ADDR_PIN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_act && !sw_stby) |-> (pin_oe[k] && pin_o[k] == addr_bits[k])); // R6

      AST_STBY_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_act && sw_stby && !hold) |-> !pin_oe[k]); // R9

      AST_STBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_act && sw_stby && hold && $past(!sw_stby))
          |-> (pin_oe[k] && pin_o[k] == $past(addr_bits[k]))); // R9
    end else begin : g_port_only
      always_comb begin
        pin_o[k]  = dat_q[k];
        pin_oe[k] = dir_q[k];
      end
    end
  end

  AST_SINGLE_FOLLOWS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE) |-> (pin_oe == dir_q && pin_o == dat_q)); // R5

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int NA     = 4,
  parameter int BUS_AW = 24,
  parameter int DEC_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              man_rst_i,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              hold_i,
  input  logic [1:0]        mode_i,
  input  logic [NA-1:0]     aen_i,
  input  logic [NA-1:0]     addr_bits_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o
);

  logic         rst_n;
  logic [W-1:0] pin_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] dat_q;
  logic         unused_addr_hi;
  op_mode_e     mode;

  assign unused_addr_hi = ^bus_addr_i[BUS_AW-1:DEC_AW];
  assign mode           = op_mode_e'(mode_i);

  gpio_rst_sync i_rst_sync (
    .clk         (clk_i),
    .rst_n_async (rst_n_i),
    .rst_n_sync  (rst_n)
  );

  gpio_pin_sync #(.W(W)) i_pin_sync (
    .clk     (clk_i),
    .pin_raw (pin_i),
    .pin_q   (pin_q)
  );

  gpio_reg_file #(.W(W), .DEC_AW(DEC_AW)) i_reg_file (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .man_rst  (man_rst_i),
    .hw_stby  (hw_stby_i),
    .dec_addr (bus_addr_i[DEC_AW-1:0]),
    .wr_en    (wr_en_i),
    .wdata    (wdata_i),
    .pin_q    (pin_q),
    .dir_q    (dir_q),
    .dat_q    (dat_q),
    .rdata    (rdata_o)
  );

  gpio_pin_mux #(.W(W), .NA(NA)) i_pin_mux (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .mode      (mode),
    .aen       (aen_i),
    .addr_bits (addr_bits_i),
    .sw_stby   (sw_stby_i),
    .hold      (hold_i),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe_o)
  );

  AST_POR_CLEARS_OE: assert property (@(posedge clk_i)
    (!rst_n && !$isunknown(rst_n)) |=> (!rst_n || pin_oe_o == '0 || mode != MODE_SINGLE)); // R1

endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

  localparam logic [15:0] A_DIR = 16'hFE30;
  localparam logic [15:0] A_DAT = 16'hFF00;
  localparam logic [15:0] A_PIN = 16'hFFB0;

  logic        clk;
  logic        rst_n;
  logic        man_rst, hw_stby, sw_stby, hold;
  logic [1:0]  mode;
  logic [3:0]  aen, abits;
  logic [23:0] baddr;
  logic        wr_en;
  logic [7:0]  wdata, rdata, pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  gpio_port_regs i_gpio_port_regs (
    .clk_i(clk), .rst_n_i(rst_n), .man_rst_i(man_rst), .hw_stby_i(hw_stby),
    .sw_stby_i(sw_stby), .hold_i(hold), .mode_i(mode), .aen_i(aen),
    .addr_bits_i(abits), .bus_addr_i(baddr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    baddr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] v);
    @(negedge clk);
    baddr = a;
    #1 v = rdata;
  endtask

  function automatic logic [15:0] exp_pins(input logic [1:0] m, input logic [3:0] en,
                                           input logic [7:0] dir, input logic [7:0] dat,
                                           input logic [3:0] ab);
    logic [7:0] o, oe;
    for (int k = 0; k < 8; k++) begin
      if (m != 2'd3 && k < 4 && en[k]) begin
        o[k] = ab[k]; oe[k] = 1'b1;
      end else begin
        o[k] = dat[k]; oe[k] = dir[k];
      end
    end
    return {oe, o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; man_rst = 0; hw_stby = 0; sw_stby = 0; hold = 0;
    mode = 2'd3; aen = 0; abits = 0; baddr = 0; wr_en = 0; wdata = 0; pin_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    #1 check(pin_oe, 8'h00, "R1 oe after reset");
    rd({8'h00, A_DAT}, v); check(v, 8'h00, "R1 data after reset");

    // R2 output register sweep, upper address bits varied
    for (int d = 0; d < 256; d++) begin
      wr({8'(d * 7), A_DAT}, 8'(d));
      rd({8'(d * 13 + 1), A_DAT}, v);
      check(v, d, "R2 data readback");
    end

    // R3 direction register write-only
    wr({8'h5A, A_DIR}, 8'hC3);
    rd({8'h00, A_DIR}, v); check(v, 8'hFF, "R3 dir reads ones");
    #1 check(pin_oe, 8'hC3, "R3 dir write reaches oe");

    // R4 pin-state one register stage
    @(negedge clk) baddr = {8'h00, A_PIN}; pin_in = 8'hFF;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk) pin_in = 8'(p);
      #1 check(rdata, 8'(p == 0 ? 8'hFF : p - 1), "R4 before edge");
      @(posedge clk); #1 check(rdata, p, "R4 after edge");
    end

    // R5/R6 mode x enable sweep
    for (int pi = 0; pi < 3; pi++) begin
      logic [7:0] dv, tv;
      dv = (pi == 0) ? 8'hFF : (pi == 1) ? 8'h00 : 8'h96;
      tv = (pi == 0) ? 8'hA5 : (pi == 1) ? 8'h3C : 8'h5F;
      wr({8'h00, A_DIR}, dv);
      wr({8'h00, A_DAT}, tv);
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 16; e++) begin
          for (int ab = 0; ab < 16; ab += 5) begin
            logic [15:0] ex;
            mode = 2'(m); aen = 4'(e); abits = 4'(ab);
            #1 ex = exp_pins(2'(m), 4'(e), dv, tv, 4'(ab));
            check({pin_oe, pin_out}, ex, (m == 3) ? "R5 single-chip pins" : "R6 address pins");
          end
        end
      end
    end

    // R10 unmapped address
    wr({8'h00, A_DIR}, 8'h0F);
    wr({8'h00, A_DAT}, 8'h66);
    mode = 2'd3;
    wr({8'h00, 16'hFE31}, 8'hF0);
    wr({8'h00, 16'h0000}, 8'h11);
    rd({8'h00, A_DAT}, v); check(v, 8'h66, "R10 data unchanged");
    #1 check(pin_oe, 8'h0F, "R10 dir unchanged");
    rd({8'h00, 16'h1234}, v); check(v, 8'h00, "R10 unmapped read zero");

    // R8 manual reset keeps registers, ignores writes
    @(negedge clk) man_rst = 1'b1;
    wr({8'h00, A_DAT}, 8'h99);
    wr({8'h00, A_DIR}, 8'hF0);
    #1 check({pin_oe, pin_out}, {8'h0F, 8'h66}, "R8 pins from retained regs");
    rd({8'h00, A_DAT}, v); check(v, 8'h66, "R8 data retained");
    @(negedge clk) man_rst = 1'b0;

    // R7 hardware standby clears direction only
    wr({8'h00, A_DIR}, 8'hFF);
    @(negedge clk) hw_stby = 1'b1;
    @(posedge clk); #1 check(pin_oe, 8'h00, "R7 dir cleared");
    @(negedge clk) hw_stby = 1'b0;
    rd({8'h00, A_DAT}, v); check(v, 8'h66, "R7 data retained");
    #1 check(pin_oe, 8'h00, "R7 dir stays clear");

    // R9 software standby hold / float
    wr({8'h00, A_DIR}, 8'hF0);
    wr({8'h00, A_DAT}, 8'h5A);
    @(negedge clk) mode = 2'd0; aen = 4'hF; abits = 4'hA; hold = 1'b1;
    @(negedge clk) sw_stby = 1'b1; abits = 4'h5;
    #1 check({pin_oe, pin_out}, {8'hFF, 8'h5A}, "R9 hold keeps last address");
    @(posedge clk); #1 check(pin_out[3:0], 4'hA, "R9 held across edge");
    @(negedge clk) hold = 1'b0;
    #1 check(pin_oe, 8'hF0, "R9 float address pins");
    rd({8'h00, A_DAT}, v); check(v, 8'h5A, "R9 data retained");
    @(negedge clk) sw_stby = 1'b0;
    #1 check({pin_oe[3:0], pin_out[3:0]}, {4'hF, 4'h5}, "R9 live address after standby");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule